// File: doc/BRIEF.md
# DRAM Refresh Arbiter (Hidden-then-Forced)

This block decides when a dynamic RAM row gets refreshed while a CPU shares the memory. A slow refresh clock defines a refresh period made of a long high phase and a short low phase. During the high phase the arbiter watches the DRAM select from the CPU. In the first cycle the CPU leaves the DRAM alone, the arbiter starts a hidden refresh, which costs the CPU nothing. It makes at most one such attempt per period. With the nominal 8 µs high and 2 µs low phases and a 2 MHz CPU, this leaves 16 cycles in which a hidden refresh can land.

If the CPU keeps the DRAM selected for the whole high phase, no hidden refresh completes. On the falling edge of the refresh clock the arbiter then raises a bus request toward the CPU. It waits until the CPU reports through both of its bus-status outputs that the address and data buses are released, and then runs a forced refresh. The bus request stays up through the forced refresh and drops when it ends. Each completed refresh, hidden or forced, advances a row counter, which feeds the row address used by the refresh strobes. Generating the RAS/CAS waveforms is left to a neighbouring block, which uses `ref_active` as its strobe window.

The controller has four states. `ST_IDLE` waits. It moves to `ST_HIDDEN` when the refresh clock is high, the DRAM is not selected and no refresh has yet completed this period. It moves to `ST_REQ` on a falling refresh-clock edge when no refresh completed this period. `ST_HIDDEN` counts `REF_CYC` cycles and returns to `ST_IDLE`. `ST_REQ` holds the bus request until both grant inputs are high, then moves to `ST_FORCED`. `ST_FORCED` counts `REF_CYC` cycles and returns to `ST_IDLE`. A per-period "refreshed" flag is set when either refresh finishes and is cleared on the rising refresh-clock edge. In the cycle of a rising edge, the flag already counts as clear.

Top module: `dram_refresh_arb`

## Requirements
- R1: After reset, `row_addr` is 0, and `bus_req`, `ref_active`, `ref_forced` and `cpu_hold` are 0.
- R2: A hidden refresh (`ref_active`=1 with `ref_forced`=0) starts only on a clock edge where `rfclk`=1 and `dram_sel`=0 were sampled. It lasts exactly `REF_CYC` (default 4) cycles.
- R3: At most one hidden refresh occurs per refresh-clock period, even when the DRAM is idle for the whole high phase.
- R4: If no refresh completed since the last rising `rfclk` edge, `bus_req` goes to 1 in the cycle after the first low `rfclk` sample that follows a high one.
- R5: A forced refresh (`ref_forced`=1) begins only on an edge where `grant_ba`=1 and `grant_bs`=1. With only `grant_ba` high, `bus_req` stays 1 and no forced refresh starts.
- R6: A forced refresh lasts exactly `REF_CYC` cycles with `bus_req` held at 1. `bus_req` returns to 0 in the first cycle after it ends.
- R7: `row_addr` increases by 1 after every completed refresh, hidden or forced, and wraps from 2^`ROW_W`-1 (default 127) to 0. It does not change otherwise.
- R8: A hidden refresh in progress is not aborted by `dram_sel`. While it runs, `cpu_hold` = `dram_sel`. Outside a hidden refresh, `cpu_hold` is 0.
- R9: When a hidden refresh has completed in a period, `bus_req` stays 0 through that period's low phase, even if the hidden refresh ran past the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfclk | input | 1 | Refresh clock, synchronous to `clk` |
| dram_sel | input | 1 | CPU is selecting the DRAM this cycle |
| grant_ba | input | 1 | CPU bus-available status |
| grant_bs | input | 1 | CPU bus-state status |
| bus_req | output | 1 | Bus request to the CPU |
| ref_active | output | 1 | A refresh (hidden or forced) is in progress |
| ref_forced | output | 1 | The refresh in progress is a forced one |
| cpu_hold | output | 1 | Holds off a CPU DRAM access during a hidden refresh |
| row_addr | output | ROW_W | Row to refresh |

## Verification
The main function is driven one refresh period at a time. The CPU releases the DRAM at the start, in the middle, or in the last cycle of the high phase. Each of these must give a single hidden refresh and no bus request; the last one shows that a hidden refresh started late may run past the falling edge. The CPU also stays busy through the whole high phase with grants that come at once or late, and it frees the DRAM exactly as the low phase begins. These must give a forced refresh; the last one shows that a free bus in the low phase does not trigger a hidden refresh. Directed tests then cover a half grant (BA without BS), a CPU select arriving during a hidden refresh, and the row counter wrapping.

// File: rtl/refresh_arb_pkg.sv
package refresh_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HIDDEN = 2'd1,
        ST_REQ    = 2'd2,
        ST_FORCED = 2'd3
    } arb_state_t;

endpackage

// File: rtl/rfclk_edge.sv
module rfclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rfclk,
    output logic rise,
    output logic fall
);

    logic rf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= 1'b0;
        else        rf_q <= rfclk;
    end

    assign rise = rfclk & ~rf_q;
    assign fall = ~rfclk & rf_q;

endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);

    always_ff @(posedge clk) begin
        if (!rst_n)    row <= '0;
        else if (step) row <= row + 1'b1;
    end

endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
    import refresh_arb_pkg::*;
#(
    parameter int REF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rf_level,
    input  logic rf_rise,
    input  logic rf_fall,
    input  logic dram_sel,
    input  logic grant_ba,
    input  logic grant_bs,
    output logic bus_req,
    output logic ref_active,
    output logic ref_forced,
    output logic cpu_hold,
    output logic finish
);

    localparam int CNT_W = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;
    localparam logic [CNT_W-1:0] DUR_LOAD = CNT_W'(REF_CYC - 1);

    arb_state_t       state, state_nx;
    logic [CNT_W-1:0] dur;
    logic             refreshed;
    logic             refreshed_eff;
    logic             load_dur;

    // A new period begins at the rising edge: the old flag no longer counts.
    assign refreshed_eff = refreshed & ~rf_rise;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (rf_level && !refreshed_eff && !dram_sel)
                    state_nx = ST_HIDDEN;
                else if (rf_fall && !refreshed_eff)
                    state_nx = ST_REQ;
            end
            ST_HIDDEN: begin
                if (dur == '0) state_nx = ST_IDLE;
            end
            ST_REQ: begin
                if (grant_ba && grant_bs) state_nx = ST_FORCED;
            end
            ST_FORCED: begin
                if (dur == '0) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign load_dur = (state != state_nx) &&
                      ((state_nx == ST_HIDDEN) || (state_nx == ST_FORCED));

    always_ff @(posedge clk) begin
        if (!rst_n)          dur <= '0;
        else if (load_dur)   dur <= DUR_LOAD;
        else if (dur != '0)  dur <= dur - 1'b1;
    end

    assign finish = ((state == ST_HIDDEN) || (state == ST_FORCED)) && (dur == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)       refreshed <= 1'b0;
        else if (finish)  refreshed <= 1'b1;
        else if (rf_rise) refreshed <= 1'b0;
    end

    // Outputs
    always_comb begin
        bus_req    = 1'b0;
        ref_active = 1'b0;
        ref_forced = 1'b0;
        cpu_hold   = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_HIDDEN: begin
                ref_active = 1'b1;
                cpu_hold   = dram_sel;
            end
            ST_REQ:    bus_req = 1'b1;
            ST_FORCED: begin
                bus_req    = 1'b1;
                ref_active = 1'b1;
                ref_forced = 1'b1;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/dram_refresh_arb.sv
module dram_refresh_arb #(
    parameter int ROW_W   = 7,
    parameter int REF_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rfclk,
    input  logic             dram_sel,
    input  logic             grant_ba,
    input  logic             grant_bs,
    output logic             bus_req,
    output logic             ref_active,
    output logic             ref_forced,
    output logic             cpu_hold,
    output logic [ROW_W-1:0] row_addr
);

    logic rf_rise, rf_fall, finish;

    rfclk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .rfclk (rfclk),
        .rise  (rf_rise),
        .fall  (rf_fall)
    );

    refresh_fsm #(.REF_CYC(REF_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rf_level   (rfclk),
        .rf_rise    (rf_rise),
        .rf_fall    (rf_fall),
        .dram_sel   (dram_sel),
        .grant_ba   (grant_ba),
        .grant_bs   (grant_bs),
        .bus_req    (bus_req),
        .ref_active (ref_active),
        .ref_forced (ref_forced),
        .cpu_hold   (cpu_hold),
        .finish     (finish)
    );

    refresh_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (finish),
        .row   (row_addr)
    );

endmodule

// File: rtl/dram_refresh_arb_chk.sv
module dram_refresh_arb_chk #(
    parameter int ROW_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rfclk,
    input logic             dram_sel,
    input logic             grant_ba,
    input logic             grant_bs,
    input logic             bus_req,
    input logic             ref_active,
    input logic             ref_forced,
    input logic             cpu_hold,
    input logic [ROW_W-1:0] row_addr
);

    p_hidden_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ref_active) && !ref_forced) |-> ($past(rfclk) && !$past(dram_sel)));

    p_forced_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_forced) |-> ($past(grant_ba) && $past(grant_bs) && $past(bus_req)));

    p_req_in_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_forced |-> (bus_req && ref_active));

    p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_active) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1)));

    p_row_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ref_active) |-> $stable(row_addr));

    p_hold_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold |-> (ref_active && !ref_forced && dram_sel));

endmodule

bind dram_refresh_arb dram_refresh_arb_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rfclk      (rfclk),
    .dram_sel   (dram_sel),
    .grant_ba   (grant_ba),
    .grant_bs   (grant_bs),
    .bus_req    (bus_req),
    .ref_active (ref_active),
    .ref_forced (ref_forced),
    .cpu_hold   (cpu_hold),
    .row_addr   (row_addr)
);

// File: tb/dram_refresh_arb_tb.sv
module dram_refresh_arb_tb;

    localparam int CLK_P   = 10;
    localparam int ROW_W   = 7;
    localparam int REF_CYC = 4;
    localparam int HI      = 16;
    localparam int LO      = 14;
    localparam int NVEC    = 6;

    // {free_at, grant_delay, exp_hidden_cycles, exp_forced_cycles, exp_req_seen}
    localparam int VEC [NVEC][5] = '{
        '{0,  0, REF_CYC, 0,       0},
        '{7,  0, REF_CYC, 0,       0},
        '{15, 0, REF_CYC, 0,       0},
        '{99, 0, 0,       REF_CYC, 1},
        '{99, 3, 0,       REF_CYC, 1},
        '{16, 1, 0,       REF_CYC, 1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rfclk = 1'b0;
    logic             dram_sel = 1'b0;
    logic             grant_ba = 1'b0;
    logic             grant_bs = 1'b0;
    logic             bus_req, ref_active, ref_forced, cpu_hold;
    logic [ROW_W-1:0] row_addr;

    int n_chk = 0;
    int n_bad = 0;
    int exp_row = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dram_refresh_arb #(.ROW_W(ROW_W), .REF_CYC(REF_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .rfclk(rfclk), .dram_sel(dram_sel),
        .grant_ba(grant_ba), .grant_bs(grant_bs), .bus_req(bus_req),
        .ref_active(ref_active), .ref_forced(ref_forced),
        .cpu_hold(cpu_hold), .row_addr(row_addr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic run_period(input int free_at, input int gdel,
                              output int hid, output int frc, output int req);
        int wait_c;
        hid = 0; frc = 0; req = 0; wait_c = 0;
        for (int c = 0; c < HI + LO; c++) begin
            @(negedge clk);
            if (ref_active && !ref_forced) hid++;
            if (ref_forced) frc++;
            if (bus_req) begin req++; wait_c++; end
            else wait_c = 0;
            rfclk    = (c < HI);
            dram_sel = (c < free_at);
            if (bus_req && wait_c > gdel) begin grant_ba = 1'b1; grant_bs = 1'b1; end
            else begin grant_ba = 1'b0; grant_bs = 1'b0; end
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int hid, frc, req, ok, guard;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 row", int'(row_addr), 0);
        check("R1 outputs", int'({bus_req, ref_active, ref_forced, cpu_hold}), 0);

        // Table walk: R2 R3 R4 R6 R7 R9
        for (int v = 0; v < NVEC; v++) begin
            run_period(VEC[v][0], VEC[v][1], hid, frc, req);
            exp_row = (exp_row + 1) % (1 << ROW_W);
            check(VEC[v][2] != 0 ? "R3 hidden cycles" : "R2 no hidden", hid, VEC[v][2]);
            check("R6 forced cycles", frc, VEC[v][3]);
            check(VEC[v][4] != 0 ? "R4 req raised" : "R9 no req", int'(req > 0), VEC[v][4]);
            check("R7 row step", int'(row_addr), exp_row);
        end

        // R5: BA alone does not start a forced refresh
        for (int c = 0; c < HI; c++) begin
            @(negedge clk); rfclk = 1'b1; dram_sel = 1'b1;
        end
        @(negedge clk); rfclk = 1'b0;
        @(negedge clk);
        check("R4 req after fall", int'(bus_req), 1);
        grant_ba = 1'b1; grant_bs = 1'b0;
        ok = 1;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (ref_forced || !bus_req) ok = 0;
        end
        check("R5 half grant ignored", ok, 1);
        grant_bs = 1'b1;
        @(negedge clk);
        check("R5 full grant starts", int'(ref_forced), 1);
        repeat (REF_CYC - 1) @(negedge clk);
        check("R6 forced held", int'(ref_forced && bus_req), 1);
        @(negedge clk);
        check("R6 req released", int'(bus_req || ref_forced), 0);
        grant_ba = 1'b0; grant_bs = 1'b0;
        exp_row = (exp_row + 1) % (1 << ROW_W);
        check("R7 row after forced", int'(row_addr), exp_row);
        repeat (LO) @(negedge clk);

        // R8: CPU select during hidden refresh is held off
        @(negedge clk); rfclk = 1'b1; dram_sel = 1'b0;
        @(negedge clk);
        check("R2 hidden at rise", int'(ref_active && !ref_forced), 1);
        check("R8 no hold idle cpu", int'(cpu_hold), 0);
        dram_sel = 1'b1;
        #1;
        check("R8 hold asserted", int'(cpu_hold), 1);
        ok = 1;
        for (int c = 0; c < REF_CYC - 1; c++) begin
            @(negedge clk);
            if (!ref_active) ok = 0;
        end
        check("R8 hidden not aborted", ok, 1);
        @(negedge clk);
        check("R8 hold released", int'(cpu_hold || ref_active), 0);
        req = 0;
        for (int c = 0; c < HI + LO - REF_CYC - 2; c++) begin
            @(negedge clk);
            rfclk = (c < HI - REF_CYC - 2);
            if (bus_req) req++;
        end
        check("R9 no req after hidden", req, 0);
        exp_row = (exp_row + 1) % (1 << ROW_W);
        check("R7 row after hidden", int'(row_addr), exp_row);

        // R7: wrap of the row counter
        guard = 0;
        while (row_addr != {ROW_W{1'b1}} && guard < 300) begin
            run_period(0, 0, hid, frc, req);
            guard++;
        end
        check("R7 reached top", int'(row_addr), (1 << ROW_W) - 1);
        run_period(0, 0, hid, frc, req);
        check("R7 wrap to zero", int'(row_addr), 0);
        check("R3 single hidden in wrap period", hid, REF_CYC);

        summary();
    end

endmodule